// File: doc/BRIEF.md
# Miss-Ranked Block Table

This block keeps a small table that pairs memory block addresses with the number of cache misses seen for each block. The table is always sorted so that the block with the most misses sits at index 0. A cache controller reports each miss as a block address on a single-cycle strobe. If the address is already in the table, its counter rises by one and the entry moves up past any entries that now have fewer misses. If the address is new and an empty slot remains, the address is taken in with a count of one. Empty slots are slots whose count is zero.

Several requesters, such as a first-level and a second-level replacement unit, can each ask for the miss count of any address through their own combinational lookup port. A victim chooser can then prefer blocks with few misses. A lock controller gives the number of ways it wants to lock. The block answers with a mask over the ranked entries that marks the top entries as lock candidates. The number of candidates scales with the locked share of the ways, and entries with no misses are left out.

Top module: `miss_rank_table`

## Requirements
- R1: Each entry holds a block address and its miss count. A strobe whose address is stored raises that entry's count by exactly one, and the new count is visible from the cycle after the strobe's clock edge.
- R2: After every clock edge, counts do not rise from index 0 toward the last index.
- R3: When an entry's count goes from c to c+1, it moves up to the position of the first entry that held count c. All other entries keep their relative order, so entries with equal counts stay in their previous order.
- R4: The table has DEPTH = CACHE_BYTES / LINE_BYTES entries (16 with the defaults, 2048 / 128).
- R5: A strobe for an address that is not stored, while the last entry has count zero, writes the address with count one into the first slot whose count is zero.
- R6: A strobe for an address that is not stored, while every entry has a nonzero count, is dropped and leaves the whole table unchanged.
- R7: A count that has reached 2^CNT_W-1 stays at that value on further strobes, and the table does not change.
- R8: The candidate limit is n = DEPTH*lock_ways_i/WAYS (integer division), clamped to DEPTH. cand_valid_o[i] can be 1 only for i < n. Entry i's address appears on cand_addr_o[i*ADDR_W +: ADDR_W].
- R9: An entry with count zero never has cand_valid_o set, even when its index is below the limit.
- R10: Each of the N_RD lookup ports independently returns the stored count for its address with look_miss_o low. An address that is not stored returns count zero with look_miss_o high.
- R11: After reset all counts are zero, no candidate is valid and every lookup misses. At most one strobe is taken per clock edge, and strobes on consecutive edges are each applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| miss_valid_i | input | 1 | Miss event strobe |
| miss_addr_i | input | ADDR_W | Block address of the miss |
| lock_ways_i | input | LW_W | Number of ways to be locked |
| look_addr_i | input | N_RD*ADDR_W | Lookup addresses, one per requester |
| look_cnt_o | output | N_RD*CNT_W | Miss counts returned per requester |
| look_miss_o | output | N_RD | Address not present in the table, per requester |
| cand_addr_o | output | DEPTH*ADDR_W | Addresses in ranked order |
| cand_valid_o | output | DEPTH | Lock candidate flags per rank |

## Verification
The bench drives three equal-count entries and then promotes the last one. A design that swaps only adjacent entries, or swaps non-adjacently, either breaks the descending order or scrambles the tie order. It also fills every slot, sends one more new address and checks that the table is unchanged; a design that evicts the last entry would lose a counted block. Three hundred repeats of one address check that the count saturates, since a wrapping counter would drop to the bottom of the ranking. Lock limits of zero, a quarter, all ways and an out-of-range value are applied to a partly filled table. Wrong scaling, a missing clamp, or offering empty slots all show up directly on the candidate mask.

// File: rtl/mrt_pkg.sv
`timescale 1ns/1ps
package mrt_pkg;
  localparam int unsigned DEF_ADDR_W = 16;
  localparam int unsigned DEF_CNT_W  = 8;

  // candidate limit: depth * lw / ways, clamped to depth
  function automatic int unsigned lock_count(int unsigned depth, int unsigned ways,
                                             int unsigned lw);
    int unsigned n;
    n = (depth * lw) / ways;
    return (n > depth) ? depth : n;
  endfunction
endpackage

// File: rtl/mrt_update.sv
`timescale 1ns/1ps
module mrt_update #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0][ADDR_W-1:0] addr_q,
  input  logic [DEPTH-1:0][CNT_W-1:0]  cnt_q,
  input  logic                         miss_valid_i,
  input  logic [ADDR_W-1:0]            miss_addr_i,
  output logic [DEPTH-1:0][ADDR_W-1:0] addr_d,
  output logic [DEPTH-1:0][CNT_W-1:0]  cnt_d
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             hit_any;
  logic             upd;
  logic [IDX_W-1:0] src_idx;
  logic [IDX_W-1:0] dst_idx;
  logic [CNT_W-1:0] src_cnt;

  always_comb begin
    hit_any = 1'b0;
    src_idx = IDX_W'(DEPTH - 1);
    for (int i = 0; i < DEPTH; i++) begin
      if (cnt_q[i] != '0 && addr_q[i] == miss_addr_i) begin
        hit_any = 1'b1;
        src_idx = IDX_W'(i);
      end
    end
    src_cnt = cnt_q[src_idx];
    upd = miss_valid_i && (hit_any ? (src_cnt != CNT_MAX) : (cnt_q[DEPTH-1] == '0));
    // head of the run of equal counts at or above the source
    dst_idx = src_idx;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (IDX_W'(i) <= src_idx && cnt_q[i] == src_cnt) dst_idx = IDX_W'(i);
    end
  end

  // rotate [dst..src] down by one and insert the bumped entry at dst
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      int p;
      p = (i == 0) ? 0 : i - 1;
      addr_d[i] = addr_q[i];
      cnt_d[i]  = cnt_q[i];
      if (upd) begin
        if (IDX_W'(i) == dst_idx) begin
          addr_d[i] = miss_addr_i;
          cnt_d[i]  = src_cnt + CNT_W'(1);
        end else if (IDX_W'(i) > dst_idx && IDX_W'(i) <= src_idx) begin
          addr_d[i] = addr_q[p];
          cnt_d[i]  = cnt_q[p];
        end
      end
    end
  end
endmodule

// File: rtl/mrt_lookup.sv
`timescale 1ns/1ps
module mrt_lookup #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic [DEPTH-1:0][ADDR_W-1:0] addr_q,
  input  logic [DEPTH-1:0][CNT_W-1:0]  cnt_q,
  input  logic [ADDR_W-1:0]            look_addr_i,
  output logic [CNT_W-1:0]             look_cnt_o,
  output logic                         look_miss_o
);
  always_comb begin
    look_cnt_o  = '0;
    look_miss_o = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      if (cnt_q[i] != '0 && addr_q[i] == look_addr_i) begin
        look_cnt_o  = cnt_q[i];
        look_miss_o = 1'b0;
      end
    end
  end
endmodule

// File: rtl/mrt_select.sv
`timescale 1ns/1ps
module mrt_select #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 8,
  parameter int WAYS  = 8,
  localparam int LW_W = $clog2(WAYS + 1)
) (
  input  logic [DEPTH-1:0][CNT_W-1:0] cnt_q,
  input  logic [LW_W-1:0]             lock_ways_i,
  output logic [DEPTH-1:0]            cand_valid_o
);
  int unsigned limit;

  always_comb begin
    limit = mrt_pkg::lock_count(DEPTH, WAYS, 32'(lock_ways_i));
    for (int i = 0; i < DEPTH; i++) begin
      cand_valid_o[i] = ($unsigned(i) < limit) && (cnt_q[i] != '0);
    end
  end
endmodule

// File: rtl/miss_rank_table.sv
`timescale 1ns/1ps
module miss_rank_table #(
  parameter int ADDR_W      = mrt_pkg::DEF_ADDR_W,
  parameter int CNT_W       = mrt_pkg::DEF_CNT_W,
  parameter int CACHE_BYTES = 2048,
  parameter int LINE_BYTES  = 128,
  parameter int WAYS        = 8,
  parameter int N_RD        = 2,
  localparam int DEPTH      = CACHE_BYTES / LINE_BYTES,
  localparam int LW_W       = $clog2(WAYS + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    miss_valid_i,
  input  logic [ADDR_W-1:0]       miss_addr_i,
  input  logic [LW_W-1:0]         lock_ways_i,
  input  logic [N_RD*ADDR_W-1:0]  look_addr_i,
  output logic [N_RD*CNT_W-1:0]   look_cnt_o,
  output logic [N_RD-1:0]         look_miss_o,
  output logic [DEPTH*ADDR_W-1:0] cand_addr_o,
  output logic [DEPTH-1:0]        cand_valid_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [DEPTH-1:0][ADDR_W-1:0] addr_q, addr_d;
  logic [DEPTH-1:0][CNT_W-1:0]  cnt_q, cnt_d;

  mrt_update #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_update (
    .addr_q       (addr_q),
    .cnt_q        (cnt_q),
    .miss_valid_i (miss_valid_i),
    .miss_addr_i  (miss_addr_i),
    .addr_d       (addr_d),
    .cnt_d        (cnt_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else begin
      addr_q <= addr_d;
      cnt_q  <= cnt_d;
    end
  end

  for (genvar g = 0; g < N_RD; g++) begin : g_look
    mrt_lookup #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_look (
      .addr_q      (addr_q),
      .cnt_q       (cnt_q),
      .look_addr_i (look_addr_i[g*ADDR_W +: ADDR_W]),
      .look_cnt_o  (look_cnt_o[g*CNT_W +: CNT_W]),
      .look_miss_o (look_miss_o[g])
    );

    p_absent_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      look_miss_o[g] |-> look_cnt_o[g*CNT_W +: CNT_W] == '0);
  end

  mrt_select #(.DEPTH(DEPTH), .CNT_W(CNT_W), .WAYS(WAYS)) u_select (
    .cnt_q        (cnt_q),
    .lock_ways_i  (lock_ways_i),
    .cand_valid_o (cand_valid_o)
  );

  for (genvar g = 0; g < DEPTH; g++) begin : g_cand
    assign cand_addr_o[g*ADDR_W +: ADDR_W] = addr_q[g];
  end

  // presence seen independently of the update path, for the checks below
  logic [DEPTH-1:0] present_v;
  always_comb begin
    for (int i = 0; i < DEPTH; i++)
      present_v[i] = (cnt_q[i] != '0) && (addr_q[i] == miss_addr_i);
  end

  for (genvar g = 0; g < DEPTH - 1; g++) begin : g_order
    p_sorted_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q[g] >= cnt_q[g+1]);
    p_cand_prefix_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cand_valid_o[g+1] |-> cand_valid_o[g]);
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_sat
    p_sat_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (miss_valid_i && present_v[g] && cnt_q[g] == CNT_MAX)
      |=> ($stable(cnt_q) && $stable(addr_q)));
  end

  p_drop_full_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_valid_i && present_v == '0 && cnt_q[DEPTH-1] != '0)
    |=> ($stable(cnt_q) && $stable(addr_q)));

  p_top_mono_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q[0] >= $past(cnt_q[0]));

  p_top_step_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, cnt_q[0]} <= {1'b0, $past(cnt_q[0])} + (CNT_W+1)'(1));
endmodule

// File: tb/miss_rank_table_bench.sv
`timescale 1ns/1ps
module miss_rank_table_bench;
  localparam int ADDR_W = 16;
  localparam int CNT_W  = 8;
  localparam int DEPTH  = 16;
  localparam int WAYS   = 8;
  localparam int N_RD   = 2;
  localparam int LW_W   = 4;
  localparam int CMAX   = 255;

  logic                    clk_i = 1'b0;
  logic                    rst_ni = 1'b0;
  logic                    miss_valid_i = 1'b0;
  logic [ADDR_W-1:0]       miss_addr_i = '0;
  logic [LW_W-1:0]         lock_ways_i = LW_W'(WAYS);
  logic [N_RD*ADDR_W-1:0]  look_addr_i = '0;
  logic [N_RD*CNT_W-1:0]   look_cnt_o;
  logic [N_RD-1:0]         look_miss_o;
  logic [DEPTH*ADDR_W-1:0] cand_addr_o;
  logic [DEPTH-1:0]        cand_valid_o;

  miss_rank_table u_miss_rank_table (
    .clk_i, .rst_ni, .miss_valid_i, .miss_addr_i, .lock_ways_i,
    .look_addr_i, .look_cnt_o, .look_miss_o, .cand_addr_o, .cand_valid_o
  );

  always #4 clk_i = ~clk_i;

  int m_addr[DEPTH];
  int m_cnt[DEPTH];
  int checks = 0;
  int errors = 0;
  int lw_cur = WAYS;
  bit done = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_limit(int lw);
    int n;
    n = DEPTH * lw / WAYS;
    return (n > DEPTH) ? DEPTH : n;
  endfunction

  task automatic model_miss(int a);
    int pos;
    pos = -1;
    for (int i = 0; i < DEPTH; i++) if (m_cnt[i] != 0 && m_addr[i] == a) pos = i;
    if (pos >= 0) begin
      if (m_cnt[pos] < CMAX) begin
        m_cnt[pos]++;
        while (pos > 0 && m_cnt[pos-1] < m_cnt[pos]) begin
          int ta, tc;
          ta = m_addr[pos-1]; tc = m_cnt[pos-1];
          m_addr[pos-1] = m_addr[pos]; m_cnt[pos-1] = m_cnt[pos];
          m_addr[pos] = ta; m_cnt[pos] = tc;
          pos--;
        end
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (pos < 0 && m_cnt[i] == 0) begin
          pos = i;
          m_addr[i] = a;
          m_cnt[i] = 1;
        end
      end
    end
  endtask

  task automatic look_one(int a, string req);
    look_addr_i = {ADDR_W'(a), ADDR_W'(a)};
    #0.1;
    for (int p = 0; p < N_RD; p++) begin
      int ec;
      ec = 0;
      for (int i = 0; i < DEPTH; i++) if (m_cnt[i] != 0 && m_addr[i] == a) ec = m_cnt[i];
      chk(int'(look_cnt_o[p*CNT_W +: CNT_W]) == ec, req, "lookup count", int'(look_cnt_o[p*CNT_W +: CNT_W]), ec);
      chk(look_miss_o[p] == (ec == 0), req, "lookup miss flag", int'(look_miss_o[p]), int'(ec == 0));
    end
  endtask

  task automatic compare_all(string req);
    int n;
    n = exp_limit(lw_cur);
    for (int i = 0; i < DEPTH; i++) begin
      bit ev;
      ev = (i < n) && (m_cnt[i] != 0);
      chk(cand_valid_o[i] == ev, req, $sformatf("cand_valid[%0d]", i), int'(cand_valid_o[i]), int'(ev));
      if (m_cnt[i] != 0)
        chk(int'(cand_addr_o[i*ADDR_W +: ADDR_W]) == m_addr[i], req,
            $sformatf("rank %0d address", i), int'(cand_addr_o[i*ADDR_W +: ADDR_W]), m_addr[i]);
    end
    for (int i = 0; i < DEPTH; i++) if (m_cnt[i] != 0) look_one(m_addr[i], req);
  endtask

  task automatic do_reset();
    miss_valid_i = 1'b0;
    rst_ni = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin m_addr[i] = 0; m_cnt[i] = 0; end
    @(negedge clk_i);
  endtask

  task automatic miss(int a, string req);
    miss_valid_i = 1'b1;
    miss_addr_i = ADDR_W'(a);
    @(posedge clk_i);
    model_miss(a);
    @(negedge clk_i);
    compare_all(req);
  endtask

  task automatic idle();
    miss_valid_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic set_lw(int lw, string req);
    lock_ways_i = LW_W'(lw);
    lw_cur = lw;
    #0.1;
    compare_all(req);
  endtask

  initial begin
    do_reset();
    // R11 reset state
    for (int i = 0; i < DEPTH; i++)
      chk(cand_valid_o[i] == 1'b0, "R11", "reset cand_valid", int'(cand_valid_o[i]), 0);
    look_one(0, "R11");
    look_one('h123, "R10");

    // R1 R2 basic ranking, back-to-back strobes
    miss('h0A0, "R1");
    miss('h0B0, "R1");
    miss('h0B0, "R2");
    miss('h0C0, "R2");
    miss('h0C0, "R2");
    miss('h0C0, "R2");
    idle();
    chk(int'(cand_addr_o[0 +: ADDR_W]) == 'h0C0, "R2", "top address", int'(cand_addr_o[0 +: ADDR_W]), 'h0C0);
    // R10 two ports at once
    look_addr_i = {ADDR_W'('h0A0), ADDR_W'('h0C0)};
    #0.1;
    chk(int'(look_cnt_o[0 +: CNT_W]) == 3, "R10", "port0 count", int'(look_cnt_o[0 +: CNT_W]), 3);
    chk(int'(look_cnt_o[CNT_W +: CNT_W]) == 1, "R10", "port1 count", int'(look_cnt_o[CNT_W +: CNT_W]), 1);

    // R3 stable promotion past an equal run
    do_reset();
    miss('h111, "R5");
    miss('h222, "R5");
    miss('h333, "R5");
    miss('h333, "R3");
    miss('h222, "R3");
    idle();
    chk(int'(cand_addr_o[1*ADDR_W +: ADDR_W]) == 'h222, "R3", "rank1 after tie promote",
        int'(cand_addr_o[1*ADDR_W +: ADDR_W]), 'h222);

    // R9 R8 candidate limits on partly filled table
    set_lw(2, "R8");
    set_lw(0, "R8");
    set_lw(15, "R8");
    set_lw(WAYS, "R9");

    // R4 R5 fill all slots, R6 drop on full
    do_reset();
    for (int i = 0; i < DEPTH; i++) miss('h400 + i, "R4");
    miss('h7FF, "R6");
    idle();
    look_one('h7FF, "R6");
    set_lw(2, "R8");
    set_lw(WAYS, "R8");
    miss('h400 + DEPTH - 1, "R3");
    idle();

    // R7 saturation
    do_reset();
    for (int i = 0; i < 300; i++) miss('h0AA, "R7");
    miss('h0BB, "R7");
    idle();
    look_one('h0AA, "R7");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8.0 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule